// File: doc/BRIEF.md
# Charger Mode and Status Supervisor

This block is the digital supervisor of a single-cell battery charger whose power stage can also run in reverse as a boost converter feeding the input rail. Every clock it weighs the configuration bits (high-impedance request, boost select, charge inhibit, status enable, OTG enable), two pins (charge-off and OTG), an input-undervoltage flag and two groups of fault flags. From these it selects one of four operating modes, which it holds in a register and presents as a 2-bit code. A one-cycle strobe marks each change of mode.

The block also drives an open-drain status line, modelled as an output enable with a data value tied low. The line is pulled low while a charge is actually running and status reporting is enabled. A newly risen fault pulls it low for a fixed time of about 128 µs, counted in clock cycles. Otherwise the line is released.

The fault flag that counts for the pulse depends on the path. On the boost path it is any boost fault. On the charge path it is any charge fault or input undervoltage. All inputs are synchronous to the clock.

Top module: `chg_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released: mode is high-impedance (code 2'b00), the status enable is 0 and the change strobe is 0.
- R2: When the high-impedance bit is 1, the mode registered at the next edge is high-impedance (2'b00), whatever the boost select, pins and faults are.
- R3: On the charge path (high-impedance bit 0, no boost request), with the charge-off pin low, input not under voltage and no charge fault, the mode becomes charge (2'b01).
- R4: On the charge path, with any charge fault bit set and the input not under voltage, the mode becomes charge-configure (2'b10).
- R5: On the charge path, input undervoltage gives high-impedance mode (2'b00), whether or not charge faults are present. It also counts as a fault for the status pulse.
- R6: On the charge path, the charge-off pin high gives high-impedance mode (2'b00).
- R7: A boost request is either the boost-select bit at 1, or the OTG pin high while the OTG-enable bit is 1. The OTG pin has no effect while OTG enable is 0. With high-impedance at 0, a boost request with no boost fault gives boost mode (2'b11).
- R8: On the boost path, any boost fault bit gives charge-configure (2'b10). Charge faults and undervoltage do not change the boost mode and start no status pulse.
- R9: With no pulse running, the status enable is 1 exactly when the registered mode is charge, the charge-inhibit bit is 0 and the status-enable bit is 1.
- R10: A rise of the path's fault flag drives the status enable to 1 for exactly PULSE_US × CLK_HZ / 1e6 clock cycles, starting with the edge that sees the rise. After that the line is released unless R9 holds.
- R11: A fault rise seen while a pulse is running neither restarts nor lengthens that pulse.
- R12: The change strobe is 1 for exactly the cycle after an edge at which the registered mode changed, and 0 otherwise.
- R13: The status data output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hiz_bit | input | 1 | High-impedance request bit |
| boost_sel | input | 1 | Operation-mode bit, 1 selects boost |
| chg_inhibit | input | 1 | Charge enable, active low (1 inhibits charging) |
| stat_en | input | 1 | Status reporting enable bit |
| otg_en | input | 1 | Allows the OTG pin to request boost |
| chg_off_pin | input | 1 | Charge-off pin, high forces high-impedance on the charge path |
| otg_pin | input | 1 | OTG request pin |
| vin_low | input | 1 | Input below undervoltage threshold |
| chg_faults | input | N_CHG_FLT | Charge-path fault flags |
| bst_faults | input | N_BST_FLT | Boost-path fault flags |
| mode | output | 2 | Registered mode: 00 high-Z, 01 charge, 10 configure, 11 boost |
| mode_chg | output | 1 | One-cycle mode-change strobe |
| stat_oe | output | 1 | Status line pull-down enable |
| stat_dat | output | 1 | Status line data, constant 0 |

## Verification
The bench keeps CLK_HZ at 125 MHz and lowers PULSE_US to 1. This makes the status pulse 125 cycles long, so several complete pulses fit in a short run. Their first and last cycles, and a fault that drops and rises again mid-pulse, are checked cycle by cycle. The fault widths stay at their defaults of eight charge and five boost flags, and faults are raised on bits other than bit 0 so that the OR over each group is exercised.

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int PULSE_US  = 128,
  parameter int N_CHG_FLT = 8,
  parameter int N_BST_FLT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hiz_bit,
  input  logic                 boost_sel,
  input  logic                 chg_inhibit,
  input  logic                 stat_en,
  input  logic                 otg_en,
  input  logic                 chg_off_pin,
  input  logic                 otg_pin,
  input  logic                 vin_low,
  input  logic [N_CHG_FLT-1:0] chg_faults,
  input  logic [N_BST_FLT-1:0] bst_faults,
  output logic [1:0]           mode,
  output logic                 mode_chg,
  output logic                 stat_oe,
  output logic                 stat_dat
);
  localparam int PULSE_CYC = CLK_HZ / 1_000_000 * PULSE_US;
  localparam int CW = $clog2(PULSE_CYC + 1);

  localparam logic [1:0] M_HIZ = 2'b00;
  localparam logic [1:0] M_CHG = 2'b01;
  localparam logic [1:0] M_CFG = 2'b10;
  localparam logic [1:0] M_BST = 2'b11;

  logic [1:0]    mode_q, mode_d;
  logic          fault_now, fault_q;
  logic [CW-1:0] cnt;

  wire boost_req = boost_sel | (otg_pin & otg_en);
  wire chg_flt   = |chg_faults;
  wire bst_flt   = |bst_faults;

  assign fault_now = boost_req ? bst_flt : (chg_flt | vin_low);

  always_comb begin
    if (hiz_bit)                      mode_d = M_HIZ;
    else if (boost_req)               mode_d = bst_flt ? M_CFG : M_BST;
    else if (chg_off_pin || vin_low)  mode_d = M_HIZ;
    else if (chg_flt)                 mode_d = M_CFG;
    else                              mode_d = M_CHG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_HIZ;
      mode_chg <= 1'b0;
      fault_q  <= 1'b0;
      cnt      <= '0;
    end else begin
      mode_q   <= mode_d;
      mode_chg <= (mode_d != mode_q);
      fault_q  <= fault_now;
      if (cnt != '0)
        cnt <= cnt - CW'(1);
      else if (fault_now && !fault_q)
        cnt <= CW'(PULSE_CYC);
    end
  end

  wire charging = (mode_q == M_CHG) & ~chg_inhibit;

  assign mode     = mode_q;
  assign stat_oe  = (cnt != '0) | (charging & stat_en);
  assign stat_dat = 1'b0;

  // R2
  hiz_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_bit |=> (mode == M_HIZ));

  // R8
  boost_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_bit && boost_req && bst_flt) |=> (mode == M_CFG));

  // R12
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg == (mode != $past(mode)));

  // R11
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> ($past(cnt) == '0 && cnt == CW'(PULSE_CYC)));
endmodule

// File: tb/chg_mode_ctrl_test.sv
module chg_mode_ctrl_test;
  localparam int PUL = 125;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hiz_bit = 0, boost_sel = 0, chg_inhibit = 0, stat_en = 0, otg_en = 0;
  logic chg_off_pin = 0, otg_pin = 0, vin_low = 0;
  logic [7:0] chg_faults = '0;
  logic [4:0] bst_faults = '0;
  logic [1:0] mode;
  logic mode_chg, stat_oe, stat_dat;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] m;
    logic       oe;
    logic       stb;
    bit         use_stb;
    string      req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  chg_mode_ctrl #(.CLK_HZ(125_000_000), .PULSE_US(1)) uut (
    .clk(clk), .rst_n(rst_n), .hiz_bit(hiz_bit), .boost_sel(boost_sel),
    .chg_inhibit(chg_inhibit), .stat_en(stat_en), .otg_en(otg_en),
    .chg_off_pin(chg_off_pin), .otg_pin(otg_pin), .vin_low(vin_low),
    .chg_faults(chg_faults), .bst_faults(bst_faults),
    .mode(mode), .mode_chg(mode_chg), .stat_oe(stat_oe), .stat_dat(stat_dat));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic oe, input string req,
                      input bit use_stb = 0, input logic stb = 0);
    exp_t e;
    e.m = m; e.oe = oe; e.stb = stb; e.use_stb = use_stb; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " mode"}, mode, e.m);
      chk({e.req, " stat_oe"}, {1'b0, stat_oe}, {1'b0, e.oe});
      chk("R13 stat_dat", {1'b0, stat_dat}, 2'b00);
      if (e.use_stb) chk({e.req, " strobe"}, {1'b0, mode_chg}, {1'b0, e.stb});
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 2'b00);
    chk("R1 reset stat_oe", {1'b0, stat_oe}, 2'b00);
    chk("R1 reset strobe", {1'b0, mode_chg}, 2'b00);
    rst_n = 1;
    // R3 / R12
    step(2'b01, 0, "R3", 1, 1);
    step(2'b01, 0, "R12", 1, 0);
    stat_en = 1;     step(2'b01, 1, "R9");
    chg_inhibit = 1; step(2'b01, 0, "R9");
    chg_inhibit = 0;
    hiz_bit = 1;     step(2'b00, 0, "R2", 1, 1);
    boost_sel = 1;   step(2'b00, 0, "R2", 1, 0);
    hiz_bit = 0;     step(2'b11, 0, "R7", 1, 1);
    chg_faults[5] = 1; vin_low = 1; step(2'b11, 0, "R8");
    chg_faults = '0; vin_low = 0;   step(2'b11, 0, "R8");
    // R10 pulse on boost fault, R11 re-rise mid pulse
    bst_faults[3] = 1; step(2'b10, 1, "R8", 1, 1);
    for (int i = 1; i < PUL; i++) begin
      bst_faults[3] = !(i >= 40 && i < 50);
      step(bst_faults[3] ? 2'b10 : 2'b11, 1, "R11");
    end
    step(2'b10, 0, "R10");
    bst_faults = '0; boost_sel = 0; step(2'b01, 1, "R3");
    otg_pin = 1;     step(2'b01, 1, "R7");
    otg_en = 1;      step(2'b11, 0, "R7");
    otg_pin = 0;     step(2'b01, 1, "R7");
    chg_faults[6] = 1; step(2'b10, 1, "R4");
    for (int i = 1; i < PUL; i++) step(2'b10, 1, "R10");
    step(2'b10, 0, "R10");
    chg_faults = '0; step(2'b01, 1, "R3");
    chg_off_pin = 1; step(2'b00, 0, "R6");
    chg_off_pin = 0; step(2'b01, 1, "R6");
    vin_low = 1;     step(2'b00, 1, "R5");
    chg_faults[1] = 1; step(2'b00, 1, "R5");
    for (int i = 2; i < PUL; i++) step(2'b00, 1, "R5");
    step(2'b00, 0, "R10");
    vin_low = 0; chg_faults = '0; step(2'b01, 1, "R3");
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule